// File: doc/BRIEF.md
# Erase and Program Sequencer

This block is the back end of a serial flash command path. The command decoder hands it one request at a time. Each request has a two-bit operation kind, a 24-bit byte address and one data byte. The sequencer turns the address into the base of the array region that the operation covers. It then gives the array a single one-cycle strobe for the whole region: an erase strobe that writes ones, or a program strobe that carries the data byte. After that it runs a self-timed interval on its own counter.

The operation kinds are encoded as follows: 0 is a 4 KB small-sector erase, 1 is a 64 KB sector erase, 2 is a whole-array erase and 3 is a single-location program. Each kind has its own duration parameter, and the defaults are short enough for simulation. While an interval runs, the ready output is low. It goes high again by itself when the interval ends, with no further command. Requests that arrive while the block is busy are dropped, because nothing is queued. The array address is 19 bits wide (a 512 KB array), so request address bits 23..19 never reach the array.

Top module: `erase_prog_seq`

## Requirements
- R1: After reset, ready is 1, arrErase and arrProg are 0, and arrAddr is 0.
- R2: A small-sector erase (kind 0) is accepted when reqValid is high and ready is high. One cycle later it raises arrErase for one cycle with arrSpan = 0 and arrAddr = {reqAddr[18:12], 12'b0}. Bits 23..19 of the address have no effect.
- R3: A sector erase (kind 1) raises arrErase with arrSpan = 1 and arrAddr = {reqAddr[18:16], 16'b0}. Bits 23..19 have no effect.
- R4: A whole-array erase (kind 2) raises arrErase with arrSpan = 2 and arrAddr = 0, whatever the request address is.
- R5: A program (kind 3) raises arrProg for one cycle with arrSpan = 3, arrAddr = reqAddr[18:0] and arrData = reqData.
- R6: Ready is low for exactly T_SMALL, T_SECTOR, T_CHIP or T_PROG cycles, according to the kind, counted from the cycle after acceptance. It then returns to 1 by itself.
- R7: A request presented while ready is low causes no strobe, leaves arrAddr unchanged and does not lengthen the busy interval.
- R8: arrErase and arrProg are never high together, and each strobe lasts exactly one cycle for each accepted request.
- R9: A request presented in the final busy cycle is dropped. If the same request is still held when ready returns, it is accepted in that first ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Operation kind (0 small erase, 1 sector erase, 2 array erase, 3 program) |
| reqAddr | input | 24 | Request byte address |
| reqData | input | 8 | Byte to program |
| ready | output | 1 | Status bit: 1 idle, 0 operation running |
| arrAddr | output | 19 | Array address (region base or byte address) |
| arrSpan | output | 2 | Region size of the current strobe, same code as reqKind |
| arrErase | output | 1 | One-cycle write-ones strobe for the region |
| arrProg | output | 1 | One-cycle program strobe |
| arrData | output | 8 | Data for the program strobe |

## Verification
Two events can land on the same clock edge: the end of the running timer and the arrival of a new request. The bench provokes this by raising a program request in the last cycle in which ready is still low, and it holds that request. The check passes only if no strobe appears on the edge where ready rises, and if the held request is accepted one cycle later with a full-length busy interval behind it.

// File: rtl/erase_prog_pkg.sv
package erase_prog_pkg;

  typedef enum logic [1:0] {
    OP_SMALL  = 2'd0,
    OP_SECTOR = 2'd1,
    OP_CHIP   = 2'd2,
    OP_PROG   = 2'd3
  } opKind_t;

  typedef struct packed {
    logic    capture;
    opKind_t kind;
  } seqStrobes_t;

endpackage

// File: rtl/erase_prog_ctrl.sv
module erase_prog_ctrl
  import erase_prog_pkg::*;
#(
  parameter int T_SMALL  = 20,
  parameter int T_SECTOR = 40,
  parameter int T_CHIP   = 60,
  parameter int T_PROG   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  output logic        ready,
  output seqStrobes_t strb
);

  localparam int T_MAX_A = (T_SMALL > T_SECTOR) ? T_SMALL : T_SECTOR;
  localparam int T_MAX_B = (T_CHIP > T_PROG) ? T_CHIP : T_PROG;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int CNT_W   = $clog2(T_MAX + 1);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             accept;
  opKind_t          kindIn;

  assign kindIn = opKind_t'(reqKind);
  assign accept = reqValid && !running;
  assign ready  = !running;

  always_comb begin
    strb.capture = accept;
    strb.kind    = kindIn;
  end

  always_comb begin
    case (kindIn)
      OP_SMALL:  loadVal = CNT_W'(T_SMALL - 1);
      OP_SECTOR: loadVal = CNT_W'(T_SECTOR - 1);
      OP_CHIP:   loadVal = CNT_W'(T_CHIP - 1);
      default:   loadVal = CNT_W'(T_PROG - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (accept) begin
      running <= 1'b1;
      cnt     <= loadVal;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  // R6: an accepted request makes the block busy on the next cycle
  p_busy_on_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && ready |=> !ready);

  // R6: the timer reaching zero hands back ready without a command
  p_self_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    running && cnt == '0 |=> ready);

  // R7: a request during busy does not reload or stall the timer
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    running && cnt != '0 && reqValid |=> running && cnt == $past(cnt) - 1'b1);

  // R9: a request in the final busy cycle is not taken
  p_last_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    running && cnt == '0 && reqValid |=> ready);

endmodule

// File: rtl/erase_prog_dp.sv
module erase_prog_dp
  import erase_prog_pkg::*;
#(
  parameter int REQ_AW    = 24,
  parameter int ARRAY_AW  = 19,
  parameter int DATA_W    = 8,
  parameter int SMALL_AW  = 12,
  parameter int SECTOR_AW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strb,
  input  logic [REQ_AW-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  output logic [ARRAY_AW-1:0] arrAddr,
  output logic [1:0]          arrSpan,
  output logic                arrErase,
  output logic                arrProg,
  output logic [DATA_W-1:0]   arrData
);

  localparam logic [ARRAY_AW-1:0] SMALL_MASK  = {ARRAY_AW{1'b1}} << SMALL_AW;
  localparam logic [ARRAY_AW-1:0] SECTOR_MASK = {ARRAY_AW{1'b1}} << SECTOR_AW;

  logic [ARRAY_AW-1:0] localAddr;
  logic [ARRAY_AW-1:0] nextAddr;
  logic                unusedHigh;

  assign localAddr  = reqAddr[ARRAY_AW-1:0];
  assign unusedHigh = ^reqAddr[REQ_AW-1:ARRAY_AW];

  always_comb begin
    case (strb.kind)
      OP_SMALL:  nextAddr = localAddr & SMALL_MASK;
      OP_SECTOR: nextAddr = localAddr & SECTOR_MASK;
      OP_CHIP:   nextAddr = '0;
      default:   nextAddr = localAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arrAddr  <= '0;
      arrSpan  <= 2'd0;
      arrErase <= 1'b0;
      arrProg  <= 1'b0;
      arrData  <= '0;
    end else begin
      arrErase <= strb.capture && (strb.kind != OP_PROG);
      arrProg  <= strb.capture && (strb.kind == OP_PROG);
      if (strb.capture) begin
        arrAddr <= nextAddr;
        arrSpan <= strb.kind;
        if (strb.kind == OP_PROG) arrData <= reqData;
      end
    end
  end

  // R8: never both strobes at once
  p_excl_strobes_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(arrErase && arrProg));

  // R8: any strobe is a single-cycle pulse
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (arrErase || arrProg) |=> !(arrErase || arrProg));

  // R2: small-region erase base is aligned to its size
  p_small_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    arrErase && arrSpan == 2'd0 |-> arrAddr[SMALL_AW-1:0] == '0);

  // R3: sector erase base is aligned to its size
  p_sector_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    arrErase && arrSpan == 2'd1 |-> arrAddr[SECTOR_AW-1:0] == '0);

  // R4: whole-array erase always targets location zero
  p_chip_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    arrErase && arrSpan == 2'd2 |-> arrAddr == '0);

  // R5: program strobe follows a program capture with its address
  p_prog_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && strb.kind == OP_PROG |=> arrProg && arrAddr == $past(localAddr));

  // R7: with no capture the array address holds
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(arrAddr));

endmodule

// File: rtl/erase_prog_seq.sv
module erase_prog_seq
  import erase_prog_pkg::*;
#(
  parameter int REQ_AW    = 24,
  parameter int ARRAY_AW  = 19,
  parameter int DATA_W    = 8,
  parameter int SMALL_AW  = 12,
  parameter int SECTOR_AW = 16,
  parameter int T_SMALL   = 20,
  parameter int T_SECTOR  = 40,
  parameter int T_CHIP    = 60,
  parameter int T_PROG    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [REQ_AW-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  output logic                ready,
  output logic [ARRAY_AW-1:0] arrAddr,
  output logic [1:0]          arrSpan,
  output logic                arrErase,
  output logic                arrProg,
  output logic [DATA_W-1:0]   arrData
);

  seqStrobes_t strb;

  erase_prog_ctrl #(
    .T_SMALL(T_SMALL), .T_SECTOR(T_SECTOR), .T_CHIP(T_CHIP), .T_PROG(T_PROG)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .ready(ready), .strb(strb)
  );

  erase_prog_dp #(
    .REQ_AW(REQ_AW), .ARRAY_AW(ARRAY_AW), .DATA_W(DATA_W),
    .SMALL_AW(SMALL_AW), .SECTOR_AW(SECTOR_AW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqData(reqData),
    .arrAddr(arrAddr), .arrSpan(arrSpan), .arrErase(arrErase),
    .arrProg(arrProg), .arrData(arrData)
  );

endmodule

// File: tb/sim_erase_prog_seq.sv
module sim_erase_prog_seq;

  localparam int TS = 20, TSE = 40, TC = 60, TP = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        ready;
  logic [18:0] arrAddr;
  logic [1:0]  arrSpan;
  logic        arrErase, arrProg;
  logic [7:0]  arrData;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  erase_prog_seq #(.T_SMALL(TS), .T_SECTOR(TSE), .T_CHIP(TC), .T_PROG(TP)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .ready(ready), .arrAddr(arrAddr),
    .arrSpan(arrSpan), .arrErase(arrErase), .arrProg(arrProg), .arrData(arrData)
  );

  // kind, request address, data, expected array address, busy cycles
  localparam logic [60:0] VEC [8] = '{
    {2'd0, 24'hF56789, 8'h00, 19'h56000, 8'd20},
    {2'd1, 24'h3DABCD, 8'h00, 19'h50000, 8'd40},
    {2'd2, 24'hFFFFFF, 8'h00, 19'h00000, 8'd60},
    {2'd3, 24'h871234, 8'hA5, 19'h71234, 8'd10},
    {2'd0, 24'h080FFF, 8'h00, 19'h00000, 8'd20},
    {2'd1, 24'h07FFFF, 8'h00, 19'h70000, 8'd40},
    {2'd1, 24'hF8FFFF, 8'h00, 19'h00000, 8'd40},
    {2'd3, 24'h000000, 8'h5A, 19'h00000, 8'd10}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string kindTag(input logic [1:0] k);
    case (k)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic countBusy(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      n++;
      @(negedge clk);
      if (!ready) chk("R8 strobe only once", longint'(arrErase | arrProg), 0);
    end
  endtask

  task automatic runOp(input logic [1:0] k, input logic [23:0] a, input logic [7:0] d,
                       input logic [18:0] expA, input int dur);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 ready low after accept", ready, 0);
    chk({kindTag(k), " array address"}, arrAddr, expA);
    chk({kindTag(k), " span"}, arrSpan, k);
    if (k == 2'd3) begin
      chk("R5 program strobe", arrProg, 1);
      chk("R8 no erase with program", arrErase, 0);
      chk("R5 program data", arrData, d);
    end else begin
      chk({kindTag(k), " erase strobe"}, arrErase, 1);
      chk("R8 no program with erase", arrProg, 0);
    end
    countBusy(n);
    chk("R6 busy length", n, dur);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL all watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 erase idle", arrErase, 0);
    chk("R1 program idle", arrProg, 0);
    chk("R1 address zero", arrAddr, 0);

    for (int i = 0; i < 8; i++)
      runOp(VEC[i][60:59], VEC[i][58:35], VEC[i][34:27], VEC[i][26:8], int'(VEC[i][7:0]));

    // R7: requests while busy are dropped
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd2; reqAddr = 24'h123456;
    @(negedge clk);
    reqKind = 2'd3; reqAddr = 24'h04ABCD; reqData = 8'h3C;
    n = 1;
    while (!ready && n < 5000) begin
      @(negedge clk);
      if (!ready) begin
        n++;
        chk("R7 no strobe while busy", longint'(arrErase | arrProg), 0);
        chk("R7 address held", arrAddr, 0);
      end
      if (n == TC - 1) reqValid = 1'b1;
      else if (n < TC - 1) reqValid = (n % 2 == 0);
      if (n == TC) break;
    end
    chk("R7 busy length unchanged", n, TC);
    // R9: request was held through the final busy cycle
    @(negedge clk);
    chk("R9 ready back", ready, 1);
    chk("R9 no strobe on completion edge", longint'(arrErase | arrProg), 0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 held request accepted", arrProg, 1);
    chk("R9 accepted address", arrAddr, 19'h4ABCD);
    chk("R9 busy again", ready, 0);
    countBusy(n);
    chk("R9 full interval after accept", n, TP);

    // R1: reset mid-operation returns to idle
    runOp(2'd0, 24'h001000, 8'h00, 19'h01000, TS);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd1; reqAddr = 24'h020000;
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 ready after mid-op reset", ready, 1);
    chk("R1 address cleared", arrAddr, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule